// File: doc/BRIEF.md
# Instrument Status Byte with Service Request

This block holds an instrument's 8-bit status byte, the 8-bit mask that selects which status bits may raise a service request, and a small queue of 16-bit error codes. Five summary bits come from status registers elsewhere in the chip. The block copies each one straight into its own status bit. A sixth bit reports whether the error queue holds anything.

The block combines the enabled status bits into a master summary. On a rising edge of that summary it latches a request-for-service flag, and the flag drives the `srq` output. The host sees two views of the status byte:

- **Query view:** bit 6 carries the live master summary.
- **Serial-poll view:** bit 6 carries the latched request flag. A poll strobe clears that flag.

The host also writes and reads the enable mask, pushes error codes and pops them oldest first. Bus handshaking, command decoding and the event registers behind the summary bits stay outside the block.

Top module: `status_byte_srq`

## Requirements
- R1: The status byte bits are laid out as follows. Bit 0 = `sum_meas`, bit 1 = constant 0, bit 2 = error-available, bit 3 = `sum_ques`, bit 4 = `sum_msg`, bit 5 = `sum_event`, bit 7 = `sum_oper`. Every bit except bit 6 is the same in `query_byte` and `poll_byte`. Each of these bits follows its source in the same cycle, with no latching.
- R2: `query_byte[6]` is the master summary. It is the OR over all bits except bit 6 of (status bit AND enable bit). Enable bit 6 has no effect on it.
- R3: A write strobe `ren_wr` loads `ren_wdata` into the enable mask at the clock edge. `ren_rdata` returns the mask with bit 6 always 0.
- R4: When the master summary goes from 0 to 1 at a clock edge, the request flag is set after that edge. `srq` and `poll_byte[6]` both show the flag.
- R5: Once set, the request flag stays set until a clock edge with `poll_rd` high clears it. A new 0-to-1 rise of the master summary at that same edge keeps it set.
- R6: Error-available (status bit 2) is 1 exactly when the error queue holds at least one code.
- R7: The error queue holds up to DEPTH (8) codes in arrival order. `err_rdata` shows the oldest code. `err_pop` removes that code at the clock edge.
- R8: With the queue empty, `err_rdata` reads 0, and `err_pop` leaves the queue unchanged.
- R9: A push into a full queue, with no pop in the same cycle, overwrites the newest entry with OVF_CODE (16'hFF00). The queue does not grow.
- R10: A push and a pop in the same cycle both take effect. On a full queue this stores the pushed code normally. On an empty queue the pushed code becomes the only entry.
- R11: The synchronous reset `rst` clears the enable mask, the request flag and the error queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sum_meas | input | 1 | Measurement summary (bit 0) |
| sum_ques | input | 1 | Questionable summary (bit 3) |
| sum_msg | input | 1 | Message-available summary (bit 4) |
| sum_event | input | 1 | Event summary (bit 5) |
| sum_oper | input | 1 | Operation summary (bit 7) |
| ren_wr | input | 1 | Enable-mask write strobe |
| ren_wdata | input | 8 | Enable-mask write data |
| ren_rdata | output | 8 | Enable-mask read data, bit 6 is 0 |
| query_byte | output | 8 | Status byte, bit 6 = master summary |
| poll_rd | input | 1 | Serial-poll strobe, clears the request flag |
| poll_byte | output | 8 | Status byte, bit 6 = request flag |
| srq | output | 1 | Service request line |
| err_push | input | 1 | Push `err_code` into the queue |
| err_code | input | 16 | Error code to push |
| err_pop | input | 1 | Remove the oldest code |
| err_rdata | output | 16 | Oldest code, 0 when the queue is empty |

## Verification
The bound assertions check the following on every cycle:
- the two status views agree outside bit 6;
- enable bit 6 always reads as 0;
- an empty queue always reads as 0;
- error-available rises after every push;
- the request flag sets one cycle after the summary rises, holds without a poll, and clears on a poll.

Some behaviours only the bench scenarios can show, because they depend on particular history:
- the first-in-first-out order of the queue;
- the overflow code that replaces the newest entry;
- a push and a pop landing on a full or an empty queue in the same cycle;
- a poll that coincides with a fresh rise;
- a reset arriving mid-run.

// File: rtl/status_byte_srq.sv
module status_byte_srq #(
  parameter int          DEPTH    = 8,
  parameter int          CODE_W   = 16,
  parameter logic [15:0] OVF_CODE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sum_meas,
  input  logic              sum_ques,
  input  logic              sum_msg,
  input  logic              sum_event,
  input  logic              sum_oper,
  input  logic              ren_wr,
  input  logic [7:0]        ren_wdata,
  output logic [7:0]        ren_rdata,
  output logic [7:0]        query_byte,
  input  logic              poll_rd,
  output logic [7:0]        poll_byte,
  output logic              srq,
  input  logic              err_push,
  input  logic [CODE_W-1:0] err_code,
  input  logic              err_pop,
  output logic [CODE_W-1:0] err_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]        sre;
  logic              rqs, mss_q;
  logic [CODE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     head, tail;
  logic [CW-1:0]     count;

  wire       eav  = (count != '0);
  wire [7:0] base = {sum_oper, 1'b0, sum_event, sum_msg, sum_ques, eav, 1'b0, sum_meas};
  wire       mss  = |(base & sre & 8'hBF);

  wire do_pop   = err_pop & eav;
  wire full     = (count == CW'(DEPTH));
  wire ovf      = err_push & full & ~do_pop;
  wire push_add = err_push & ~ovf;

  assign ren_rdata  = sre;
  assign query_byte = base | {1'b0, mss, 6'b0};
  assign poll_byte  = base | {1'b0, rqs, 6'b0};
  assign srq        = rqs;
  assign err_rdata  = eav ? mem[head] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sre   <= '0;
      rqs   <= 1'b0;
      mss_q <= 1'b0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      mss_q <= mss;
      if (mss & ~mss_q)  rqs <= 1'b1;
      else if (poll_rd)  rqs <= 1'b0;
      if (ren_wr)        sre <= ren_wdata & 8'hBF;
      if (do_pop)        head <= head + 1'b1;
      if (push_add)      tail <= tail + 1'b1;
      count <= count + CW'(push_add) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (ovf)           mem[tail - 1'b1] <= OVF_CODE[CODE_W-1:0];
      else if (push_add) mem[tail] <= err_code;
    end
  end
endmodule

// File: rtl/status_byte_srq_chk.sv
module status_byte_srq_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        ren_rdata,
  input logic [7:0]        query_byte,
  input logic [7:0]        poll_byte,
  input logic              poll_rd,
  input logic              srq,
  input logic              err_push,
  input logic [CODE_W-1:0] err_rdata
);
  AST_VIEWS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (query_byte & 8'hBF) == (poll_byte & 8'hBF));                      // R1
  AST_SRE_B6_ZERO: assert property (@(posedge clk) disable iff (rst)
    ren_rdata[6] == 1'b0);                                             // R3
  AST_RQS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(query_byte[6]) |=> srq);                                     // R4
  AST_RQS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(srq) |-> $past(query_byte[6]));                              // R4
  AST_RQS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (srq && !poll_rd) |=> srq);                                        // R5
  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (poll_rd && !query_byte[6]) |=> !srq);                             // R5
  AST_EAV_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    err_push |=> query_byte[2]);                                       // R6
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !query_byte[2] |-> (err_rdata == '0));                             // R8
endmodule

bind status_byte_srq status_byte_srq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .ren_rdata(ren_rdata), .query_byte(query_byte),
  .poll_byte(poll_byte), .poll_rd(poll_rd), .srq(srq),
  .err_push(err_push), .err_rdata(err_rdata)
);

// File: tb/status_byte_srq_test.sv
module status_byte_srq_test;
  logic clk = 0, rst = 1;
  logic sum_meas = 0, sum_ques = 0, sum_msg = 0, sum_event = 0, sum_oper = 0;
  logic ren_wr = 0, poll_rd = 0, err_push = 0, err_pop = 0;
  logic [7:0] ren_wdata = 0;
  logic [15:0] err_code = 0;
  logic [7:0] ren_rdata, query_byte, poll_byte;
  logic srq;
  logic [15:0] err_rdata;

  status_byte_srq uut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_sre = 0;
  bit m_rqs = 0, m_mssp = 0;
  logic [15:0] m_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit eav, mss;
    int base, q, p, er;
    #1;
    eav  = (m_q.size() != 0);
    base = (sum_oper << 7) | (sum_event << 5) | (sum_msg << 4) | (sum_ques << 3) | (eav << 2) | sum_meas;
    mss  = ((base & m_sre & 'hBF) != 0);
    q    = base | (mss << 6);
    p    = base | (m_rqs << 6);
    er   = eav ? m_q[0] : 0;
    if (!rst) begin
      chk(query_byte == q, "R2", "query_byte", query_byte, q);
      chk(poll_byte == p, "R4", "poll_byte", poll_byte, p);
      chk((query_byte & 'hBF) == base, "R1", "mirror bits", query_byte & 'hBF, base);
      chk(query_byte[2] == eav, "R6", "eav", query_byte[2], eav);
      chk(srq == m_rqs, "R5", "srq", srq, m_rqs);
      chk(ren_rdata == m_sre, "R3", "ren_rdata", ren_rdata, m_sre);
      chk(err_rdata == er, eav ? "R7" : "R8", "err_rdata", err_rdata, er);
    end
    @(posedge clk);
    if (rst) begin
      m_sre = 0; m_rqs = 0; m_mssp = 0; m_q.delete();
    end else begin
      if (mss && !m_mssp) m_rqs = 1;
      else if (poll_rd) m_rqs = 0;
      m_mssp = mss;
      if (ren_wr) m_sre = ren_wdata & 'hBF;
      if (err_pop && m_q.size() > 0) void'(m_q.pop_front());
      if (err_push) begin
        if (m_q.size() == 8) m_q[7] = 16'hFF00;
        else m_q.push_back(err_code);
      end
    end
    @(negedge clk);
    ren_wr = 0; poll_rd = 0; err_push = 0; err_pop = 0;
  endtask

  task automatic push(logic [15:0] c);
    err_push = 1; err_code = c; cycle();
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(); cycle();
    rst = 0;
    // R11 reset state, R1 mirrors
    chk(ren_rdata == 0 && srq == 0 && err_rdata == 0, "R11", "reset state", {ren_rdata, 7'b0, srq}, 0);
    cycle();
    sum_meas = 1; cycle(); sum_ques = 1; cycle(); sum_msg = 1; cycle();
    sum_event = 1; cycle(); sum_oper = 1; cycle();
    sum_meas = 0; sum_msg = 0; cycle(); sum_ques = 0; sum_event = 0; sum_oper = 0; cycle();
    // R3 write with bit 6 set; R2 enable bit 6 ignored
    ren_wr = 1; ren_wdata = 8'h40; cycle();
    sum_oper = 1; cycle(); cycle();
    // R4 rise of MSS
    ren_wr = 1; ren_wdata = 8'hFF; cycle(); cycle();
    chk(srq == 1, "R4", "srq after rise", srq, 1);
    sum_oper = 0; cycle(); cycle();
    // R5 held without poll, then poll clears
    chk(srq == 1, "R5", "srq held", srq, 1);
    poll_rd = 1; cycle(); cycle();
    // R5 poll coinciding with new rise keeps flag
    sum_msg = 1; poll_rd = 1; cycle(); cycle();
    chk(srq == 1, "R5", "poll with rise", srq, 1);
    sum_msg = 0; poll_rd = 1; cycle(); cycle();
    // R6/R7 queue order, error bit drives MSS via enable bit 2
    push(16'h0011); push(16'h0022); push(16'h0033); cycle();
    err_pop = 1; cycle(); err_pop = 1; cycle(); poll_rd = 1; cycle();
    err_pop = 1; cycle();
    // R8 pop on empty
    err_pop = 1; cycle(); cycle();
    // R10 push and pop on empty
    err_push = 1; err_code = 16'h0077; err_pop = 1; cycle(); cycle();
    // R9 overflow
    for (int i = 0; i < 10; i++) push(16'h0100 + 16'(i));
    // R10 push and pop on full
    err_push = 1; err_code = 16'h0ABC; err_pop = 1; cycle();
    for (int i = 0; i < 9; i++) begin err_pop = 1; cycle(); end
    // R11 reset mid-run
    for (int i = 0; i < 3; i++) push(16'h0200 + 16'(i));
    ren_wr = 1; ren_wdata = 8'h3F; cycle();
    rst = 1; cycle(); rst = 0; cycle();
    chk(ren_rdata == 0 && err_rdata == 0 && srq == 0, "R11", "after reset", {ren_rdata, err_rdata}, 0);
    cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule